// File: doc/BRIEF.md
# Interrupt Priority and Cause Encoder

This block decides, every cycle, whether a hart must take an interrupt trap and which cause code that trap carries. It combines the pending-interrupt vector with the enable vector, splits the result into a machine-level set (not delegated) and a supervisor-level set (delegated), and gates each set by the current privilege level and by the matching global enable bit. The machine set always wins when it holds anything. Within the winning set, the block picks a group by a fixed class ranking. The lowest-numbered bit of that group becomes the cause index.

The cause is presented combinationally as an XLEN-wide word with the top bit marking an interrupt. A registered request strobe follows one cycle later for the trap sequencer. While the hart is in debug mode, nothing is requested. Trap vectoring and the saving of state are the job of the logic downstream.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `trap_req` is 0.
- R2: The machine set is pending & enable & ~delegate, restricted to bits 1, 3, 5, 7, 9 and every bit from 11 upward. It is live when `cur_priv` is not machine, or when `m_ie` is 1. The privilege encoding is user 0, supervisor 1, reserved 2, machine 3.
- R3: The supervisor set is pending & enable & delegate, restricted to the same bits. It is considered only when the live machine set is empty. It is live when `cur_priv` is user, or when `cur_priv` is supervisor and `s_ie` is 1. The reserved value 2 counts as above supervisor and below machine.
- R4: While `dbg_mode` is 1, `trap_cause` is 0 and, one cycle later, `trap_req` is 0.
- R5: Within the chosen set, groups rank in this order: every bit at or above 11 (which includes bit 11), then external (bits 9 and 11), then software (bits 1 and 3), then timer (bits 5 and 7).
- R6: Within the winning group, the lowest-numbered set bit gives the cause index.
- R7: When an interrupt wins, `trap_cause` has bit XLEN-1 set, holds the index in its low bits and has zeros elsewhere. With no winner, `trap_cause` is 0.
- R8: Pending bits 0, 2, 4, 6, 8 and 10 never produce a cause and never suppress the supervisor set.
- R9: `trap_req` is 1 exactly in the cycle after a clock edge at which `trap_cause` had bit XLEN-1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the request strobe |
| irq_pend | input | NIRQ | Pending interrupt bits |
| irq_en | input | NIRQ | Per-bit interrupt enables |
| irq_deleg | input | NIRQ | Per-bit delegation to supervisor level |
| cur_priv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| m_ie | input | 1 | Machine global interrupt enable |
| s_ie | input | 1 | Supervisor global interrupt enable |
| dbg_mode | input | 1 | Hart is in debug mode |
| trap_req | output | 1 | Registered interrupt trap request |
| trap_cause | output | XLEN | Combinational cause word, interrupt flag at bit XLEN-1 |

## Verification
The cause word is combinational, so a wrong gate, group rank or encoder shows on `trap_cause` in the same cycle as the inputs that expose it. The request strobe then disagrees one edge later. A set that loses its privilege gating shows up as a cause appearing where none is expected. A wrong group ranking shows up as a higher index winning over a lower-ranked but smaller one, for example bit 9 winning against bit 3, or bit 11 against bit 9. The bench's reference model recomputes the expected cause from the inputs and compares it on every clock. This covers the directed corners and a long random stream.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   typedef enum logic [1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   // standard interrupt bit numbers
   localparam int BIT_S_SOFT  = 1;
   localparam int BIT_M_SOFT  = 3;
   localparam int BIT_S_TIMER = 5;
   localparam int BIT_M_TIMER = 7;
   localparam int BIT_S_EXT   = 9;
   localparam int BIT_M_EXT   = 11;

   localparam int NUM_GROUPS  = 4;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
   import irq_arb_pkg::*;
#(
   parameter int NIRQ = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] pend,
   input  logic [NIRQ-1:0] en,
   input  logic [NIRQ-1:0] deleg,
   input  logic [1:0]      priv,
   input  logic            m_ie,
   input  logic            s_ie,
   input  logic            dbg,
   output logic [NIRQ-1:0] chosen
);
   logic [NIRQ-1:0] known;
   logic [NIRQ-1:0] live;
   logic [NIRQ-1:0] m_set;
   logic [NIRQ-1:0] s_set;
   logic            m_gate;
   logic            s_gate;

   for (genvar gi = 0; gi < NIRQ; gi++) begin : g_known
      assign known[gi] = (gi >= BIT_M_EXT) || (gi == BIT_S_SOFT) || (gi == BIT_M_SOFT)
                      || (gi == BIT_S_TIMER) || (gi == BIT_M_TIMER) || (gi == BIT_S_EXT);
   end

   always_comb begin
      m_gate = (priv != PRIV_M) || m_ie;
      s_gate = (priv == PRIV_U) || ((priv == PRIV_S) && s_ie);
      live   = pend & en & known;
      m_set  = live & ~deleg & {NIRQ{m_gate}};
      s_set  = live &  deleg & {NIRQ{s_gate}};
      if (dbg)
         chosen = '0;
      else if (|m_set)
         chosen = m_set;
      else
         chosen = s_set;
   end

   // R2
   chosen_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chosen & ~(pend & en)) == '0);
   // R3
   deleg_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(chosen & deleg)) |-> (priv == PRIV_U || priv == PRIV_S));
endmodule

// File: rtl/irq_class_sel.sv
module irq_class_sel
   import irq_arb_pkg::*;
#(
   parameter int NIRQ = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] chosen,
   output logic [NIRQ-1:0] group_bits
);
   logic [NIRQ-1:0] cls_mask [NUM_GROUPS];
   logic [NIRQ-1:0] hit      [NUM_GROUPS];

   for (genvar gi = 0; gi < NIRQ; gi++) begin : g_mask
      assign cls_mask[0][gi] = (gi >= BIT_M_EXT);
      assign cls_mask[1][gi] = (gi == BIT_S_EXT)   || (gi == BIT_M_EXT);
      assign cls_mask[2][gi] = (gi == BIT_S_SOFT)  || (gi == BIT_M_SOFT);
      assign cls_mask[3][gi] = (gi == BIT_S_TIMER) || (gi == BIT_M_TIMER);
   end

   for (genvar gg = 0; gg < NUM_GROUPS; gg++) begin : g_hit
      assign hit[gg] = chosen & cls_mask[gg];
   end

   always_comb begin
      group_bits = '0;
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
         if (|hit[g]) group_bits = hit[g];
      end
   end

   // R5
   grp_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(chosen & cls_mask[0])) |-> ((group_bits & ~cls_mask[0]) == '0));
endmodule

// File: rtl/lsb_enc.sv
module lsb_enc #(
   parameter int N  = 16,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   logic [N:0]   below;
   logic [N-1:0] grant;

   assign below[0] = 1'b0;
   for (genvar gi = 0; gi < N; gi++) begin : g_chain
      assign below[gi+1] = below[gi] | vec[gi];
      assign grant[gi]   = vec[gi] & ~below[gi];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IW'(i);
      end
   end

   assign any = below[N];

   // R6
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R6
   grant_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> $countones(grant) == 1);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int NIRQ = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] irq_pend,
   input  logic [NIRQ-1:0] irq_en,
   input  logic [NIRQ-1:0] irq_deleg,
   input  logic [1:0]      cur_priv,
   input  logic            m_ie,
   input  logic            s_ie,
   input  logic            dbg_mode,
   output logic            trap_req,
   output logic [XLEN-1:0] trap_cause
);
   localparam int IW = $clog2(NIRQ);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("irq_arbiter: XLEN must be 32 or 64");
   end
   if (NIRQ < BIT_M_EXT + 1 || NIRQ > XLEN) begin : g_bad_nirq
      $error("irq_arbiter: NIRQ must lie between 12 and XLEN");
   end

   logic [NIRQ-1:0] chosen;
   logic [NIRQ-1:0] group_bits;
   logic [IW-1:0]   win_idx;
   logic            win_any;
   logic            req_q;

   irq_gate #(.NIRQ(NIRQ)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .pend(irq_pend), .en(irq_en), .deleg(irq_deleg),
      .priv(cur_priv), .m_ie(m_ie), .s_ie(s_ie), .dbg(dbg_mode),
      .chosen(chosen)
   );

   irq_class_sel #(.NIRQ(NIRQ)) u_cls (
      .clk(clk), .rst_n(rst_n),
      .chosen(chosen), .group_bits(group_bits)
   );

   lsb_enc #(.N(NIRQ), .IW(IW)) u_enc (
      .clk(clk), .rst_n(rst_n),
      .vec(group_bits), .idx(win_idx), .any(win_any)
   );

   always_comb begin
      trap_cause = '0;
      if (win_any) begin
         trap_cause[XLEN-1] = 1'b1;
         trap_cause[IW-1:0] = win_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= win_any;
   end

   assign trap_req = req_q;

   // R4
   dbg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_mode |=> !trap_req);
   // R7
   cause_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_cause[XLEN-1] |-> (trap_cause[XLEN-2:IW] == '0));
   // R9
   req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(trap_cause[XLEN-1]));
   // R8
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_cause[XLEN-1] |-> (int'(trap_cause[IW-1:0]) < NIRQ));
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
   localparam int XLEN = 64;
   localparam int NIRQ = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NIRQ-1:0] irq_pend = '0;
   logic [NIRQ-1:0] irq_en = '0;
   logic [NIRQ-1:0] irq_deleg = '0;
   logic [1:0]      cur_priv = 2'd3;
   logic            m_ie = 1'b0;
   logic            s_ie = 1'b0;
   logic            dbg_mode = 1'b0;
   logic            trap_req;
   logic [XLEN-1:0] trap_cause;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    finished = 0;
   string cur_tag = "R1";

   irq_arbiter #(.XLEN(XLEN), .NIRQ(NIRQ)) dut (
      .clk(clk), .rst_n(rst_n),
      .irq_pend(irq_pend), .irq_en(irq_en), .irq_deleg(irq_deleg),
      .cur_priv(cur_priv), .m_ie(m_ie), .s_ie(s_ie), .dbg_mode(dbg_mode),
      .trap_req(trap_req), .trap_cause(trap_cause)
   );

   always #5 clk = ~clk;

   function automatic bit in_group(int i, int g);
      case (g)
         0: return i >= 11;
         1: return i == 9 || i == 11;
         2: return i == 1 || i == 3;
         default: return i == 5 || i == 7;
      endcase
   endfunction

   // returns winning index or -1
   function automatic int model(bit [NIRQ-1:0] p, bit [NIRQ-1:0] e, bit [NIRQ-1:0] d,
                                int pr, bit mie, bit sie, bit dbg);
      bit [NIRQ-1:0] ms, ss, pick;
      bit mg, sg;
      if (dbg) return -1;
      mg = (pr != 3) || mie;
      sg = (pr == 0) || (pr == 1 && sie);
      ms = '0; ss = '0;
      for (int i = 0; i < NIRQ; i++) begin
         if (p[i] && e[i] && (i >= 11 || i == 1 || i == 3 || i == 5 || i == 7 || i == 9)) begin
            if (!d[i] && mg) ms[i] = 1'b1;
            if (d[i] && sg)  ss[i] = 1'b1;
         end
      end
      pick = (ms != 0) ? ms : ss;
      for (int g = 0; g < 4; g++)
         for (int i = 0; i < NIRQ; i++)
            if (pick[i] && in_group(i, g)) return i;
      return -1;
   endfunction

   task automatic check(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // at negedge: compare outputs for the inputs applied one negedge earlier, then apply new ones
   task automatic step(string tag, bit [NIRQ-1:0] p, bit [NIRQ-1:0] e, bit [NIRQ-1:0] d,
                       int pr, bit mie, bit sie, bit dbg);
      int w;
      logic [XLEN-1:0] ec;
      @(negedge clk);
      w  = model(irq_pend, irq_en, irq_deleg, int'(cur_priv), m_ie, s_ie, dbg_mode);
      ec = (w < 0) ? '0 : ((XLEN'(1) << (XLEN-1)) | XLEN'(w));
      check(cur_tag, "cause (R7)", trap_cause, ec);
      check(cur_tag, "req (R9)", XLEN'(trap_req), XLEN'(w >= 0));
      cur_tag   = tag;
      irq_pend  = p; irq_en = e; irq_deleg = d;
      cur_priv  = pr[1:0]; m_ie = mie; s_ie = sie; dbg_mode = dbg;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      irq_pend = '1; irq_en = '1; m_ie = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "req in reset", XLEN'(trap_req), '0);
      irq_pend = '0; irq_en = '0; m_ie = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "req after reset", XLEN'(trap_req), '0);

      // R2 machine gating
      step("R2", 16'h0080, 16'hFFFF, 16'h0000, 3, 1, 0, 0);
      step("R2", 16'h0080, 16'hFFFF, 16'h0000, 3, 0, 0, 0);
      step("R2", 16'h0080, 16'hFFFF, 16'h0000, 1, 0, 0, 0);
      step("R2", 16'h0080, 16'h0000, 16'h0000, 0, 1, 0, 0);
      step("R2", 16'h0080, 16'hFFFF, 16'h0000, 2, 0, 0, 0);
      // R3 supervisor gating and machine-first
      step("R3", 16'h0020, 16'hFFFF, 16'h0020, 1, 0, 1, 0);
      step("R3", 16'h0020, 16'hFFFF, 16'h0020, 1, 0, 0, 0);
      step("R3", 16'h0020, 16'hFFFF, 16'h0020, 0, 0, 0, 0);
      step("R3", 16'h0020, 16'hFFFF, 16'h0020, 3, 1, 1, 0);
      step("R3", 16'h0020, 16'hFFFF, 16'h0020, 2, 1, 1, 0);
      step("R3", 16'h00A0, 16'hFFFF, 16'h0020, 0, 0, 0, 0);
      step("R3", 16'h0202, 16'hFFFF, 16'h0002, 1, 0, 1, 0);
      // R4 debug
      step("R4", 16'h0800, 16'hFFFF, 16'h0000, 0, 1, 1, 1);
      step("R4", 16'hFFFF, 16'hFFFF, 16'h00FF, 0, 1, 1, 1);
      // R5 group ranking
      step("R5", 16'h2200, 16'hFFFF, 16'h0000, 3, 1, 0, 0);
      step("R5", 16'h0208, 16'hFFFF, 16'h0000, 3, 1, 0, 0);
      step("R5", 16'h0028, 16'hFFFF, 16'h0000, 3, 1, 0, 0);
      step("R5", 16'h0A00, 16'hFFFF, 16'h0000, 3, 1, 0, 0);
      step("R5", 16'h0082, 16'hFFFF, 16'h0000, 3, 1, 0, 0);
      // R6 lowest index inside group
      step("R6", 16'h5000, 16'hFFFF, 16'h0000, 3, 1, 0, 0);
      step("R6", 16'h00A0, 16'hFFFF, 16'h0000, 3, 1, 0, 0);
      step("R6", 16'h000A, 16'hFFFF, 16'h0000, 3, 1, 0, 0);
      // R8 non-standard low bits ignored
      step("R8", 16'h0555, 16'hFFFF, 16'h0000, 0, 1, 1, 0);
      step("R8", 16'h05D5, 16'hFFFF, 16'h0000, 0, 1, 1, 0);
      step("R8", 16'h0575, 16'hFFFF, 16'h0020, 0, 1, 1, 0);
      step("R7", 16'h0000, 16'h0000, 16'h0000, 3, 1, 0, 0);
      // random stream
      for (int k = 0; k < 600; k++) begin
         step("R5", 16'($urandom), 16'($urandom), 16'($urandom), int'($urandom_range(0, 3)),
              1'($urandom), 1'($urandom), ($urandom_range(0, 9) == 0));
      end
      step("R9", 16'h0000, 16'h0000, 16'h0000, 3, 0, 0, 0);
      step("R9", 16'h0000, 16'h0000, 16'h0000, 3, 0, 0, 0);
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule